// File: doc/BRIEF.md
# Three-Axis Sample Buffer with Selectable Fill Policies

The block buffers X/Y/Z sensor samples. Each entry is a triple of 14-bit channel values, and the buffer holds up to 256 of them. A producer pulses a valid strobe with each triple. A host pops the oldest entry with a read strobe and sees that entry on the head outputs. The block also reports how many entries are unread, flags when that number reaches a programmable threshold, and flags overwrites of unread data.

A 3-bit mode input picks the fill policy:

- **Pass-through:** only the newest sample is held and nothing is queued.
- **Stop-when-full:** new samples are dropped while the buffer is full.
- **Streaming:** the oldest entry is replaced when the buffer is full.
- **Two trigger-driven modes:**
  - streaming that turns into stop-when-full on a trigger event;
  - pass-through that turns into streaming on a trigger event.

Selecting pass-through also clears the queue. The first sample that arrives after entering or leaving stop-when-full behaviour is thrown away.

Top module: `triaxial_sample_buffer`

## Requirements
- R1: While reset is asserted and just after it is released, `level` is 0, `empty` is 1, `ovr_flag` is 0 and `thr_flag` is 0.
- R2: Mode 000 and the unused codes 010, 101 and 111 select pass-through. In pass-through nothing is queued, `level` stays 0 and reads are ignored. A strobed sample appears on the head outputs from the next cycle and replaces the previous one.
- R3: Any cycle in pass-through leaves the buffer emptied: after that clock edge, `level` is 0 and `ovr_flag` is 0.
- R4: Mode 001 (stop-when-full) queues samples in arrival order. The head outputs show the oldest unread triple, and an accepted read removes it. A sample strobed while `level` is 256 without a read in the same cycle is dropped: `level`, the head and `ovr_flag` are unchanged. A read while `empty` is ignored.
- R5: Mode 110 (streaming) behaves like mode 001 until the buffer is full. A sample strobed while `level` is 256 without a read then drops the oldest entry and stores the new one. `level` stays 256, the head moves to the next entry, and `ovr_flag` becomes 1 after that edge.
- R6: `ovr_flag` returns to 0 on the clock edge of the next accepted read (a read while not empty).
- R7: `thr_flag` is 1 exactly when `thr` is non-zero and `level` >= `thr`. It follows `thr` combinationally and follows `level` once per clock.
- R8: `level` is a 9-bit count of unread entries ranging from 0 to 256, and `empty` is 1 exactly when `level` is 0. `level` moves by at most one per clock, except when it is cleared to 0.
- R9: When a sample is accepted and a read is accepted in the same cycle, `level` is unchanged. This includes a full buffer in mode 001.
- R10: The first sample strobed in the cycle where stop-when-full behaviour begins or ends, or at any later cycle before another sample arrives, is discarded and not queued.
- R11: Mode 011 streams until `trig` is sampled high. From the next cycle it behaves as mode 001, and R10 applies to that change.
- R12: Mode 100 is pass-through until `trig` is sampled high. From the next cycle it behaves as mode 110. A trigger stays in effect until the mode input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A new sample triple is present |
| smp_x | input | 14 | X channel of the incoming sample |
| smp_y | input | 14 | Y channel of the incoming sample |
| smp_z | input | 14 | Z channel of the incoming sample |
| rd_en | input | 1 | Host pops the head entry |
| mode | input | 3 | Fill policy select |
| thr | input | 8 | Threshold for `thr_flag`; 0 disables the flag |
| trig | input | 1 | Trigger event for modes 011 and 100 |
| head_x | output | 14 | X channel of the oldest unread entry, or of the held sample in pass-through |
| head_y | output | 14 | Y channel of the head entry |
| head_z | output | 14 | Z channel of the head entry |
| level | output | 9 | Number of unread entries |
| thr_flag | output | 1 | Unread count at or above a non-zero threshold |
| ovr_flag | output | 1 | An unread entry was overwritten |
| empty | output | 1 | No unread entries |

## Verification
Most internal faults reach the ports within one clock. A wrong pointer shows as a head triple that is out of order, and a wrong count shows as a `level` step or an `empty`/`thr_flag` mismatch on the next edge. A misplaced discard or trigger latch causes a level that lags by one entry. That lag stays visible until the next clear, because every later head value is then shifted. An overwrite fault that goes unflagged, or an `ovr_flag` that fails to clear, becomes visible at the first write into a full streaming buffer or at the first read after it.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  typedef enum logic [1:0] {
    POL_BYPASS = 2'd0,
    POL_FIFO   = 2'd1,
    POL_STREAM = 2'd2
  } pol_e;

  localparam logic [2:0] MODE_BYPASS      = 3'b000;
  localparam logic [2:0] MODE_FIFO        = 3'b001;
  localparam logic [2:0] MODE_STREAM_STOP = 3'b011;
  localparam logic [2:0] MODE_BYP_STREAM  = 3'b100;
  localparam logic [2:0] MODE_STREAM      = 3'b110;

  // Effective fill policy from the mode code and the held trigger.
  function automatic pol_e decode_policy(input logic [2:0] mode, input logic seen);
    pol_e p;
    case (mode)
      MODE_FIFO:        p = POL_FIFO;
      MODE_STREAM:      p = POL_STREAM;
      MODE_STREAM_STOP: p = seen ? POL_FIFO : POL_STREAM;
      MODE_BYP_STREAM:  p = seen ? POL_STREAM : POL_BYPASS;
      default:          p = POL_BYPASS;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/tsb_mode_ctrl.sv
module tsb_mode_ctrl
  import tsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       trig,
  input  logic       smp_valid,
  output pol_e       pol,
  output pol_e       pol_prev,
  output logic       smp_drop
);

  logic [2:0] mode_q;
  logic       seen_q, seen_d;
  pol_e       pol_q;
  logic       pend_q, pend_d;
  logic       mode_held;
  logic       seen_eff;
  logic       trig_mode;
  logic       fifo_edge;

  always_comb begin
    mode_held = (mode == mode_q);
    seen_eff  = seen_q & mode_held;
    trig_mode = (mode == MODE_STREAM_STOP) | (mode == MODE_BYP_STREAM);
    pol       = decode_policy(mode, seen_eff);
    seen_d    = trig_mode & (seen_eff | trig);
    fifo_edge = (pol == POL_FIFO) ^ (pol_q == POL_FIFO);
    smp_drop  = smp_valid & (fifo_edge | pend_q);
    pend_d    = (pol != POL_BYPASS) & (fifo_edge | pend_q) & ~smp_valid;
  end

  assign pol_prev = pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_BYPASS;
      seen_q <= 1'b0;
      pol_q  <= POL_BYPASS;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode;
      seen_q <= seen_d;
      pol_q  <= pol;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/tsb_ptr_ctrl.sv
module tsb_ptr_ctrl
  import tsb_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pol_e          pol,
  input  logic          wr_req,
  input  logic          rd_en,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] level,
  output logic          ovr_flag,
  output logic          empty
);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] level_q, level_d;
  logic          ovr_q, ovr_d;
  logic          active, stream, full;
  logic          rd_ok, wr_ok, ovw, inc, rd_adv;

  always_comb begin
    active = (pol != POL_BYPASS);
    stream = (pol == POL_STREAM);
    full   = (level_q == CW'(DEPTH));
    rd_ok  = active & rd_en & (level_q != '0);
    wr_ok  = active & wr_req & (~full | rd_ok | stream);
    ovw    = wr_ok & full & ~rd_ok;
    inc    = wr_ok & ~ovw;
    rd_adv = rd_ok | ovw;

    if (!active) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
      ovr_d    = 1'b0;
    end else begin
      wr_ptr_d = wr_ptr_q + AW'(wr_ok);
      rd_ptr_d = rd_ptr_q + AW'(rd_adv);
      level_d  = level_q + CW'(inc) - CW'(rd_ok);
      if (ovw)        ovr_d = 1'b1;
      else if (rd_ok) ovr_d = 1'b0;
      else            ovr_d = ovr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
      ovr_q    <= ovr_d;
    end
  end

  assign wr_en    = wr_ok;
  assign wr_ptr   = wr_ptr_q;
  assign rd_ptr   = rd_ptr_q;
  assign level    = level_q;
  assign ovr_flag = ovr_q;
  assign empty    = (level_q == '0);

endmodule

// File: rtl/tsb_storage.sv
module tsb_storage #(
  parameter int DATA_W = 14,
  parameter int CH_N   = 3,
  parameter int DEPTH  = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_ptr,
  input  logic [AW-1:0]               rd_ptr,
  input  logic                        hold_en,
  input  logic                        show_hold,
  input  logic [CH_N-1:0][DATA_W-1:0] din,
  output logic [CH_N-1:0][DATA_W-1:0] dout
);

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= din[ch];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= '0;
      else if (hold_en) hold_q <= din[ch];
    end

    assign dout[ch] = show_hold ? hold_q : mem[rd_ptr];
  end

endmodule

// File: rtl/tsb_thr_cmp.sv
module tsb_thr_cmp #(
  parameter int CW = 9,
  parameter int TW = 8
) (
  input  logic [CW-1:0] level,
  input  logic [TW-1:0] thr,
  output logic          flag
);

  always_comb begin
    flag = (thr != '0) && (level >= CW'(thr));
  end

endmodule

// File: rtl/triaxial_sample_buffer.sv
module triaxial_sample_buffer
  import tsb_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int DEPTH  = 256,
  parameter int THR_W  = 8,
  localparam int CH_N = 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_x,
  input  logic [DATA_W-1:0] smp_y,
  input  logic [DATA_W-1:0] smp_z,
  input  logic              rd_en,
  input  logic [2:0]        mode,
  input  logic [THR_W-1:0]  thr,
  input  logic              trig,
  output logic [DATA_W-1:0] head_x,
  output logic [DATA_W-1:0] head_y,
  output logic [DATA_W-1:0] head_z,
  output logic [CW-1:0]     level,
  output logic              thr_flag,
  output logic              ovr_flag,
  output logic              empty
);

  pol_e                        pol, pol_prev;
  logic                        smp_drop;
  logic                        wr_en;
  logic [AW-1:0]               wr_ptr, rd_ptr;
  logic [CH_N-1:0][DATA_W-1:0] din, dout;
  logic                        hold_en, show_hold;

  assign din       = {smp_x, smp_y, smp_z};
  assign hold_en   = smp_valid & (pol == POL_BYPASS);
  assign show_hold = (pol_prev == POL_BYPASS);

  tsb_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .trig     (trig),
    .smp_valid(smp_valid),
    .pol      (pol),
    .pol_prev (pol_prev),
    .smp_drop (smp_drop)
  );

  tsb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .pol     (pol),
    .wr_req  (smp_valid & ~smp_drop),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .level   (level),
    .ovr_flag(ovr_flag),
    .empty   (empty)
  );

  tsb_storage #(.DATA_W(DATA_W), .CH_N(CH_N), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .hold_en  (hold_en),
    .show_hold(show_hold),
    .din      (din),
    .dout     (dout)
  );

  tsb_thr_cmp #(.CW(CW), .TW(THR_W)) u_thr (
    .level(level),
    .thr  (thr),
    .flag (thr_flag)
  );

  assign head_x = dout[2];
  assign head_y = dout[1];
  assign head_z = dout[0];

endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
  parameter int DEPTH = 256,
  parameter int THR_W = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             rd_en,
  input logic [2:0]       mode,
  input logic [THR_W-1:0] thr,
  input logic [CW-1:0]    level,
  input logic             thr_flag,
  input logic             ovr_flag,
  input logic             empty
);

  p_level_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  p_level_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (level == $past(level)) || (level == $past(level) + 1'b1) ||
    (level + 1'b1 == $past(level)) || (level == '0));

  p_empty_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !smp_valid) |=> empty);

  p_bypass_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000) |=> (level == '0 && !ovr_flag));

  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b001 && level == CW'(DEPTH) && !rd_en) |=> (level == CW'(DEPTH)));

  p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && rd_en && !empty) |=> !ovr_flag);

  p_thr_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_flag |-> (thr != '0 && level >= CW'(thr)));

endmodule

bind triaxial_sample_buffer tsb_checker #(.DEPTH(DEPTH), .THR_W(THR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_valid(smp_valid),
  .rd_en    (rd_en),
  .mode     (mode),
  .thr      (thr),
  .level    (level),
  .thr_flag (thr_flag),
  .ovr_flag (ovr_flag),
  .empty    (empty)
);

// File: tb/triaxial_sample_buffer_tb_top.sv
module triaxial_sample_buffer_tb_top;

  localparam int CLK_P = 10;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid, rd_en, trig;
  logic [13:0] smp_x, smp_y, smp_z;
  logic [2:0]  mode;
  logic [7:0]  thr;
  logic [13:0] head_x, head_y, head_z;
  logic [8:0]  level;
  logic        thr_flag, ovr_flag, empty;

  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  triaxial_sample_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .rd_en(rd_en), .mode(mode), .thr(thr), .trig(trig),
    .head_x(head_x), .head_y(head_y), .head_z(head_z),
    .level(level), .thr_flag(thr_flag), .ovr_flag(ovr_flag), .empty(empty)
  );

  // ---------------- reference model (from the requirements) ----------------
  logic [41:0] q[$];
  logic [41:0] m_hold;
  bit          m_ovr, m_seen, m_pend;
  int          m_pol;          // 0 pass-through, 1 stop-when-full, 2 streaming
  logic [2:0]  m_mode;

  function automatic int policy_of(input logic [2:0] md, input bit seen);
    case (md)
      3'b001:  return 1;
      3'b110:  return 2;
      3'b011:  return seen ? 1 : 2;
      3'b100:  return seen ? 2 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [41:0] mk(input int i);
    logic [13:0] a, b, c;
    a = 14'(i);
    b = 14'(i * 3 + 1);
    c = 14'(i) ^ 14'h2aa;
    return {a, b, c};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_hold = '0; m_ovr = 0; m_seen = 0; m_pend = 0;
      m_pol = 0; m_mode = 3'b000;
    end else begin
      bit seen_eff, edge_f, drop, rdok, trigm;
      int pol;
      seen_eff = m_seen && (mode == m_mode);
      pol      = policy_of(mode, seen_eff);
      trigm    = (mode == 3'b011) || (mode == 3'b100);
      edge_f   = (pol == 1) != (m_pol == 1);
      drop     = smp_valid && (edge_f || m_pend);
      m_pend   = (pol != 0) && (edge_f || m_pend) && !smp_valid;
      if (pol == 0) begin
        q.delete(); m_ovr = 0;
        if (smp_valid) m_hold = {smp_x, smp_y, smp_z};
      end else begin
        rdok = rd_en && (q.size() > 0);
        if (rdok) begin void'(q.pop_front()); m_ovr = 0; end
        if (smp_valid && !drop) begin
          if (q.size() < DEPTH) q.push_back({smp_x, smp_y, smp_z});
          else if (pol == 2) begin
            void'(q.pop_front()); q.push_back({smp_x, smp_y, smp_z}); m_ovr = 1;
          end
        end
      end
      m_seen = trigm && (seen_eff || trig);
      m_mode = mode;
      m_pol  = pol;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    int exp_lvl;
    bit exp_thr;
    logic [41:0] exp_head;
    logic [41:0] act_head;
    exp_lvl = q.size();
    exp_thr = (thr != 0) && (exp_lvl >= int'(thr));
    act_head = {head_x, head_y, head_z};
    chk(level == 9'(exp_lvl), {tag, " R8 level"}, 64'(level), 64'(exp_lvl));
    chk(empty == (exp_lvl == 0), "R8 empty", 64'(empty), 64'(exp_lvl == 0));
    chk(ovr_flag == m_ovr, "R6 ovr_flag", 64'(ovr_flag), 64'(m_ovr));
    chk(thr_flag == exp_thr, "R7 thr_flag", 64'(thr_flag), 64'(exp_thr));
    if (m_pol == 0 || exp_lvl > 0) begin
      exp_head = (m_pol == 0) ? m_hold : q[0];
      chk(act_head == exp_head, {tag, " R4 head"}, 64'(act_head), 64'(exp_head));
    end
  endtask

  task automatic put(input bit v, input bit r, input logic [41:0] s);
    smp_valid = v; rd_en = r; {smp_x, smp_y, smp_z} = s;
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    tests++; fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [41:0] h;
    int unsigned seed;
    rst_n = 1'b0; mode = 3'b000; thr = '0; trig = 1'b0;
    put(0, 0, '0);
    repeat (3) @(negedge clk);
    chk(level == 0 && empty && !ovr_flag && !thr_flag, "R1 reset",
        64'({level, empty, ovr_flag, thr_flag}), 64'({9'd0, 1'b1, 1'b0, 1'b0}));
    rst_n = 1'b1;
    @(negedge clk);
    chk(level == 0 && empty, "R1 after release", 64'(level), 64'd0);

    // R2: pass-through codes
    put(1, 1, mk(1)); cyc("R2");
    put(1, 0, mk(2)); cyc("R2");
    h = {head_x, head_y, head_z};
    chk(h == mk(2), "R2 head newest", 64'(h), 64'(mk(2)));
    chk(level == 0, "R2 level", 64'(level), 64'd0);
    mode = 3'b111; put(1, 1, mk(3)); cyc("R2");
    h = {head_x, head_y, head_z};
    chk(level == 0 && h == mk(3), "R2 unused code", 64'(h), 64'(mk(3)));

    // R10 + R4: stop-when-full, first sample discarded
    mode = 3'b001;
    put(1, 0, mk(10)); cyc("R10");
    put(1, 0, mk(11)); cyc("R10");
    put(1, 0, mk(12)); cyc("R10");
    h = {head_x, head_y, head_z};
    chk(level == 2, "R10 level", 64'(level), 64'd2);
    chk(h == mk(11), "R10 head", 64'(h), 64'(mk(11)));
    for (int i = 0; i < 254; i++) begin put(1, 0, mk(100 + i)); cyc("R4"); end
    chk(level == 256, "R4 full", 64'(level), 64'd256);
    put(1, 0, mk(999)); cyc("R4");
    h = {head_x, head_y, head_z};
    chk(level == 256 && !ovr_flag, "R4 write at full ignored", 64'({level, ovr_flag}), 64'({9'd256, 1'b0}));
    chk(h == mk(11), "R4 head unchanged", 64'(h), 64'(mk(11)));
    put(0, 0, '0); thr = 8'd0; cyc("R7");
    chk(!thr_flag, "R7 zero threshold", 64'(thr_flag), 64'd0);
    thr = 8'd200; #1;
    chk(thr_flag, "R7 level over threshold", 64'(thr_flag), 64'd1);
    put(1, 1, mk(500)); cyc("R9");
    h = {head_x, head_y, head_z};
    chk(level == 256 && h == mk(12), "R9 read+write at full", 64'(level), 64'd256);
    put(0, 1, '0); cyc("R4");
    h = {head_x, head_y, head_z};
    chk(level == 255 && h == mk(100), "R4 order", 64'(h), 64'(mk(100)));

    // R3: clear by entering pass-through
    mode = 3'b000; put(0, 0, '0); cyc("R3");
    chk(level == 0 && empty && !ovr_flag, "R3 cleared", 64'(level), 64'd0);

    // R5 + R6: streaming overwrite
    mode = 3'b110;
    for (int i = 0; i < 259; i++) begin put(1, 0, mk(2000 + i)); cyc("R5"); end
    h = {head_x, head_y, head_z};
    chk(level == 256 && ovr_flag, "R5 overwrite", 64'({level, ovr_flag}), 64'({9'd256, 1'b1}));
    chk(h == mk(2003), "R5 oldest dropped", 64'(h), 64'(mk(2003)));
    put(0, 1, '0); cyc("R6");
    chk(!ovr_flag && level == 255, "R6 clear on read", 64'(ovr_flag), 64'd0);
    put(1, 1, mk(7)); cyc("R9");
    chk(level == 255, "R9 simultaneous", 64'(level), 64'd255);
    put(0, 0, '0); thr = 8'd255; #1;
    chk(thr_flag, "R7 equal threshold", 64'(thr_flag), 64'd1);
    put(0, 1, '0); cyc("R7");
    chk(!thr_flag && level == 254, "R7 below threshold", 64'(thr_flag), 64'd0);

    // R11: streaming then stop-when-full
    mode = 3'b000; put(0, 0, '0); cyc("R11");
    mode = 3'b011;
    for (int i = 0; i < 5; i++) begin put(1, 0, mk(3000 + i)); cyc("R11"); end
    chk(level == 5, "R11 streaming before trigger", 64'(level), 64'd5);
    trig = 1'b1; put(0, 0, '0); cyc("R11");
    trig = 1'b0;
    put(1, 0, mk(3100)); cyc("R11");
    chk(level == 5, "R11 first after trigger dropped", 64'(level), 64'd5);
    put(1, 0, mk(3101)); cyc("R11");
    chk(level == 6, "R11 stored after trigger", 64'(level), 64'd6);

    // R12: pass-through then streaming
    mode = 3'b000; put(0, 0, '0); cyc("R12");
    mode = 3'b100;
    for (int i = 0; i < 3; i++) begin put(1, 0, mk(4000 + i)); cyc("R12"); end
    chk(level == 0, "R12 pass-through before trigger", 64'(level), 64'd0);
    trig = 1'b1; put(0, 0, '0); cyc("R12");
    trig = 1'b0;
    put(1, 0, mk(4100)); cyc("R12");
    h = {head_x, head_y, head_z};
    chk(level == 1 && h == mk(4100), "R12 streaming after trigger", 64'(h), 64'(mk(4100)));

    // constrained random phase
    seed = 32'd1234;
    void'($urandom(seed));
    for (int n = 0; n < 6000; n++) begin
      int unsigned r;
      r = $urandom % 100;
      if ((n % 61) == 0) begin
        case ($urandom % 8)
          0: mode = 3'b000; 1: mode = 3'b001; 2: mode = 3'b011; 3: mode = 3'b100;
          4: mode = 3'b110; 5: mode = 3'b001; 6: mode = 3'b110; default: mode = 3'(3'b010 + 3'($urandom % 2) * 3'b101);
        endcase
        thr = 8'($urandom);
      end
      trig = (($urandom % 50) == 0);
      put(r < 65, ($urandom % 100) < ((n / 500) % 2 ? 60 : 25), 42'({$urandom, $urandom}));
      cyc("R8 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule